// File: doc/BRIEF.md
# In-Order Completion Buffer Queue

This block keeps a small circular queue of completion buffers for a two-wide dispatch pipeline. Every instruction leaving dispatch claims one buffer, which records the architectural destination register and the rename slot that holds the result. The buffer index is handed back to the dispatcher as the instruction's tag. Execution units later report results by that tag, in any order, and may flag the instruction as faulting. Faulting covers both exceptions and branch mispredictions.

Each cycle the queue looks at its oldest entries and retires up to two of them, strictly from the head. Each retirement is a commit pulse that names the rename slot to copy into the register file. When a faulting entry reaches the head, nothing commits. A recover pulse is raised instead, and every entry is discarded at the next clock edge. A stall output tells dispatch that no buffer can be taken this cycle.

Top module: `retq_top`

## Requirements
- R1: While reset is held and after its release the queue is empty: `stall`, `recover`, `disp_grant` and `commit_valid` are all 0.
- R2: Dispatch lanes are ordered, with lane 0 older. A valid lane is granted when the number of valid lanes below it is smaller than the free count at the start of the cycle. Granted lanes receive consecutive tags counting up modulo 5 from the tail. A tag is the buffer index in 0..4.
- R3: `stall` is 1 exactly when all five buffers are occupied at the start of the cycle, or when `recover` is 1. While `stall` is 1 no lane is granted.
- R4: A finish report sets its entry finished at the clock edge. The entry's commit can appear from the following cycle on, and never before its finish has been taken.
- R5: At most two entries commit per cycle: the head, then the next one. The second commits only if the head commits and the second is finished without a fault. Each commit lane reports the entry's tag, destination and rename slot.
- R6: An entry finished ahead of an older, unfinished entry does not commit until every older entry has committed.
- R7: A faulting entry at the head raises `recover` with no commit that cycle. At the next edge all entries are dropped. New tags then start again at the faulting entry's index.
- R8: A finish report is ignored when its tag is 5..7, when its entry is not occupied, or when its entry has already finished.
- R9: Allocation and retirement in one cycle both take effect. A queue that is full at the start of the cycle grants nothing, even while it retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Instruction offered on each dispatch lane |
| disp_dst | input | 10 | Destination register per lane, 5 bits each |
| disp_slot | input | 6 | Rename slot per lane, 3 bits each |
| disp_grant | output | 2 | Lane accepted into the queue this cycle |
| disp_tag | output | 6 | Tag assigned to each lane, 3 bits each |
| stall | output | 1 | No buffer can be claimed this cycle |
| fin_valid | input | 2 | Finish report on each report port |
| fin_tag | input | 6 | Tag of each finish report, 3 bits each |
| fin_exc | input | 2 | Report marks a fault or misprediction |
| commit_valid | output | 2 | Commit pulse per retire lane, lane 0 oldest |
| commit_tag | output | 6 | Tag of each committing entry |
| commit_dst | output | 10 | Destination register of each committing entry |
| commit_slot | output | 6 | Rename slot to copy for each committing entry |
| recover | output | 1 | Faulting entry at head; queue flushes at next edge |

## Verification
The hardest situation to reach from the ports needs three things at once. The queue must be full and wrapped. The head must still be pending while younger entries are finished. A faulting entry must sit directly behind a finished head, so that one cycle commits a single entry and the next raises recover. A directed sequence builds this: it fills the queue, finishes entries out of order, mixes in stray and repeated reports, and retires while dispatch keeps pressing. Long random runs follow, in which finish tags are drawn mostly from occupied buffers so that retirement keeps moving, with occasional faults. Every cycle is compared against a bench model of the queue.

// File: rtl/retq_pkg.sv
package retq_pkg;

   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_DONE  = 2'd2,
      SLOT_FAULT = 2'd3
   } slot_state_e;

   // circular index: (base + step) modulo depth
   function automatic int unsigned ring_idx(int unsigned base, int unsigned step,
                                            int unsigned depth);
      return (base + step) % depth;
   endfunction

endpackage

// File: rtl/retq_alloc.sv
module retq_alloc #(
   parameter int DEPTH  = 5,
   parameter int DISP_W = 2,
   parameter int TAG_W  = 3,
   parameter int CNT_W  = 3
) (
   input  logic [TAG_W-1:0]        head,
   input  logic [CNT_W-1:0]        count,
   input  logic [DISP_W-1:0]       disp_valid,
   input  logic                    recover,
   output logic [DISP_W-1:0]       grant,
   output logic [DISP_W*TAG_W-1:0] tag,
   output logic [CNT_W-1:0]        n_alloc,
   output logic                    stall
);
   import retq_pkg::*;

   logic [CNT_W-1:0] free_cnt;
   int unsigned      below [DISP_W];

   assign free_cnt = CNT_W'(DEPTH) - count;
   assign stall    = recover || (free_cnt == '0);

   always_comb begin
      int unsigned acc;
      acc = 0;
      for (int i = 0; i < DISP_W; i++) begin
         below[i] = acc;
         acc = acc + int'(disp_valid[i]);
      end
   end

   for (genvar i = 0; i < DISP_W; i++) begin : g_lane
      assign grant[i] = disp_valid[i] && !recover && (below[i] < int'(free_cnt));
      assign tag[i*TAG_W +: TAG_W] =
         TAG_W'(ring_idx(int'(head), int'(count) + below[i], DEPTH));
   end

   always_comb begin
      n_alloc = '0;
      for (int i = 0; i < DISP_W; i++) n_alloc = n_alloc + CNT_W'(grant[i]);
   end

endmodule

// File: rtl/retq_retire.sv
module retq_retire #(
   parameter int DEPTH = 5,
   parameter int RET_W = 2,
   parameter int TAG_W = 3,
   parameter int CNT_W = 3
) (
   input  logic [TAG_W-1:0]         head,
   input  logic [CNT_W-1:0]         count,
   input  retq_pkg::slot_state_e    st [DEPTH],
   output logic [RET_W-1:0]         ret_en,
   output logic [RET_W*TAG_W-1:0]   ret_idx,
   output logic [CNT_W-1:0]         n_ret,
   output logic                     recover
);
   import retq_pkg::*;

   assign recover = (count != '0) && (st[head] == SLOT_FAULT);

   for (genvar r = 0; r < RET_W; r++) begin : g_ret
      logic [TAG_W-1:0] idx;
      logic             cand;
      assign idx  = TAG_W'(ring_idx(int'(head), r, DEPTH));
      assign cand = (r < int'(count)) && (st[idx] == SLOT_DONE);
      assign ret_idx[r*TAG_W +: TAG_W] = idx;
      if (r == 0) begin : g_first
         assign ret_en[r] = cand;
      end else begin : g_next
         assign ret_en[r] = cand && ret_en[r-1];
      end
   end

   always_comb begin
      n_ret = '0;
      for (int r = 0; r < RET_W; r++) n_ret = n_ret + CNT_W'(ret_en[r]);
   end

endmodule

// File: rtl/retq_top.sv
module retq_top #(
   parameter int DEPTH  = 5,
   parameter int DISP_W = 2,
   parameter int RET_W  = 2,
   parameter int FIN_N  = 2,
   parameter int REG_W  = 5,
   parameter int SLOT_W = 3,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DISP_W-1:0]         disp_valid,
   input  logic [DISP_W*REG_W-1:0]   disp_dst,
   input  logic [DISP_W*SLOT_W-1:0]  disp_slot,
   output logic [DISP_W-1:0]         disp_grant,
   output logic [DISP_W*TAG_W-1:0]   disp_tag,
   output logic                      stall,
   input  logic [FIN_N-1:0]          fin_valid,
   input  logic [FIN_N*TAG_W-1:0]    fin_tag,
   input  logic [FIN_N-1:0]          fin_exc,
   output logic [RET_W-1:0]          commit_valid,
   output logic [RET_W*TAG_W-1:0]    commit_tag,
   output logic [RET_W*REG_W-1:0]    commit_dst,
   output logic [RET_W*SLOT_W-1:0]   commit_slot,
   output logic                      recover
);
   import retq_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("retq_top: DEPTH must be at least 2");
   end
   if (DISP_W < 1 || DISP_W > DEPTH) begin : g_bad_disp
      $error("retq_top: DISP_W must lie in 1..DEPTH");
   end
   if (RET_W < 1 || RET_W > DEPTH) begin : g_bad_ret
      $error("retq_top: RET_W must lie in 1..DEPTH");
   end
   if (FIN_N < 1) begin : g_bad_fin
      $error("retq_top: FIN_N must be at least 1");
   end

   slot_state_e        st_q   [DEPTH];
   logic [REG_W-1:0]   dst_q  [DEPTH];
   logic [SLOT_W-1:0]  slot_q [DEPTH];
   logic [TAG_W-1:0]   head_q;
   logic [CNT_W-1:0]   count_q;

   logic [RET_W-1:0]       ret_en;
   logic [RET_W*TAG_W-1:0] ret_idx;
   logic [CNT_W-1:0]       n_ret;
   logic [CNT_W-1:0]       n_alloc;
   logic [TAG_W-1:0]       fin_t [FIN_N];
   logic [DEPTH-1:0]       occ;

   retq_retire #(.DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_retire (
      .head    (head_q),
      .count   (count_q),
      .st      (st_q),
      .ret_en  (ret_en),
      .ret_idx (ret_idx),
      .n_ret   (n_ret),
      .recover (recover)
   );

   retq_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_alloc (
      .head       (head_q),
      .count      (count_q),
      .disp_valid (disp_valid),
      .recover    (recover),
      .grant      (disp_grant),
      .tag        (disp_tag),
      .n_alloc    (n_alloc),
      .stall      (stall)
   );

   for (genvar f = 0; f < FIN_N; f++) begin : g_fin
      assign fin_t[f] = fin_tag[f*TAG_W +: TAG_W];
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_occ
      assign occ[e] = (st_q[e] != SLOT_EMPTY);
   end

   // entry state, head and occupancy
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) st_q[e] <= SLOT_EMPTY;
         head_q  <= '0;
         count_q <= '0;
      end else if (recover) begin
         for (int e = 0; e < DEPTH; e++) st_q[e] <= SLOT_EMPTY;
         count_q <= '0;
      end else begin
         for (int f = 0; f < FIN_N; f++) begin
            if (fin_valid[f] && (int'(fin_t[f]) < DEPTH) && (st_q[fin_t[f]] == SLOT_WAIT))
               st_q[fin_t[f]] <= fin_exc[f] ? SLOT_FAULT : SLOT_DONE;
         end
         for (int r = 0; r < RET_W; r++) begin
            if (ret_en[r]) st_q[ret_idx[r*TAG_W +: TAG_W]] <= SLOT_EMPTY;
         end
         for (int d = 0; d < DISP_W; d++) begin
            if (disp_grant[d]) st_q[disp_tag[d*TAG_W +: TAG_W]] <= SLOT_WAIT;
         end
         head_q  <= TAG_W'(ring_idx(int'(head_q), int'(n_ret), DEPTH));
         count_q <= count_q + n_alloc - n_ret;
      end
   end

   // payload: written only on allocation
   always_ff @(posedge clk) begin
      for (int d = 0; d < DISP_W; d++) begin
         if (disp_grant[d]) begin
            dst_q[disp_tag[d*TAG_W +: TAG_W]]  <= disp_dst[d*REG_W +: REG_W];
            slot_q[disp_tag[d*TAG_W +: TAG_W]] <= disp_slot[d*SLOT_W +: SLOT_W];
         end
      end
   end

   for (genvar r = 0; r < RET_W; r++) begin : g_commit
      logic [TAG_W-1:0] ci;
      assign ci = ret_idx[r*TAG_W +: TAG_W];
      assign commit_valid[r]                 = ret_en[r];
      assign commit_tag[r*TAG_W +: TAG_W]    = ci;
      assign commit_dst[r*REG_W +: REG_W]    = dst_q[ci];
      assign commit_slot[r*SLOT_W +: SLOT_W] = slot_q[ci];
   end

   // occupancy bits and the counter agree (R2)
   p_occ_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(occ) == int'(count_q));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count_q) <= DEPTH);

   p_full_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count_q) == DEPTH) |-> stall);

   p_stall_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (disp_grant == '0));

   p_head_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid[0] |-> (st_q[head_q] == SLOT_DONE));

   if (RET_W > 1) begin : g_order_chk
      p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
         commit_valid[1] |-> commit_valid[0]);
   end

   p_recover_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      recover |-> (commit_valid == '0));

   p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (count_q == '0 && occ == '0));

endmodule

// File: tb/retq_top_test.sv
module retq_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  disp_valid = '0;
   logic [9:0]  disp_dst = '0;
   logic [5:0]  disp_slot = '0;
   logic [1:0]  disp_grant;
   logic [5:0]  disp_tag;
   logic        stall;
   logic [1:0]  fin_valid = '0;
   logic [5:0]  fin_tag = '0;
   logic [1:0]  fin_exc = '0;
   logic [1:0]  commit_valid;
   logic [5:0]  commit_tag;
   logic [9:0]  commit_dst;
   logic [5:0]  commit_slot;
   logic        recover;

   always #2.5 clk = ~clk;

   retq_top uut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_slot(disp_slot),
      .disp_grant(disp_grant), .disp_tag(disp_tag), .stall(stall),
      .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
      .commit_valid(commit_valid), .commit_tag(commit_tag),
      .commit_dst(commit_dst), .commit_slot(commit_slot), .recover(recover)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;
   int seq = 0;

   // model: 0 empty, 1 waiting, 2 finished, 3 faulted
   int m_st [5];
   int m_dst [5];
   int m_slot [5];
   int m_head = 0;
   int m_cnt = 0;

   task automatic chk(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic cyc(input logic [1:0] dv, input logic [1:0] fv,
                      input int t0, input int t1, input logic [1:0] fe);
      int rec, r0, r1, free, pos, nal;
      int etag [2];
      int dval [2];
      int sval [2];
      int old [5];
      bit eg [2];
      @(negedge clk);
      for (int l = 0; l < 2; l++) begin
         dval[l] = (seq * 3 + l * 7) % 32;
         sval[l] = (seq + l * 5) % 8;
         disp_dst[l*5 +: 5]  = 5'(dval[l]);
         disp_slot[l*3 +: 3] = 3'(sval[l]);
      end
      seq++;
      disp_valid = dv;
      fin_valid  = fv;
      fin_tag    = {3'(t1), 3'(t0)};
      fin_exc    = fe;
      #1;
      rec = (m_cnt > 0 && m_st[m_head] == 3) ? 1 : 0;
      r0  = (!rec && m_cnt > 0 && m_st[m_head] == 2) ? 1 : 0;
      r1  = (r0 == 1 && m_cnt > 1 && m_st[(m_head + 1) % 5] == 2) ? 1 : 0;
      free = 5 - m_cnt;
      pos = 0;
      for (int l = 0; l < 2; l++) begin
         eg[l] = 0;
         etag[l] = 0;
         if (dv[l]) begin
            eg[l] = (!rec && pos < free);
            etag[l] = (m_head + m_cnt + pos) % 5;
            pos++;
         end
      end
      chk("R7", "recover", int'(recover), rec);
      chk("R3", "stall", int'(stall), (rec == 1 || free == 0) ? 1 : 0);
      chk("R2", "grant", int'(disp_grant), int'({eg[1], eg[0]}));
      for (int l = 0; l < 2; l++)
         if (eg[l]) chk("R2", "tag", int'(disp_tag[l*3 +: 3]), etag[l]);
      chk("R5", "commit_valid", int'(commit_valid), r1 * 2 + r0);
      for (int r = 0; r < 2; r++) begin
         if ((r == 0 && r0 == 1) || (r == 1 && r1 == 1)) begin
            int ix;
            ix = (m_head + r) % 5;
            chk("R5", "commit_tag", int'(commit_tag[r*3 +: 3]), ix);
            chk("R5", "commit_dst", int'(commit_dst[r*5 +: 5]), m_dst[ix]);
            chk("R5", "commit_slot", int'(commit_slot[r*3 +: 3]), m_slot[ix]);
         end
      end
      // advance the model
      if (rec == 1) begin
         for (int e = 0; e < 5; e++) m_st[e] = 0;
         m_cnt = 0;
      end else begin
         for (int e = 0; e < 5; e++) old[e] = m_st[e];
         for (int l = 0; l < 2; l++) begin
            int tg;
            tg = (l == 0) ? t0 : t1;
            if (fv[l] && tg < 5 && old[tg] == 1) m_st[tg] = fe[l] ? 3 : 2;
         end
         if (r0 == 1) m_st[m_head] = 0;
         if (r1 == 1) m_st[(m_head + 1) % 5] = 0;
         nal = 0;
         for (int l = 0; l < 2; l++) begin
            if (eg[l]) begin
               m_st[etag[l]] = 1;
               m_dst[etag[l]] = dval[l];
               m_slot[etag[l]] = sval[l];
               nal++;
            end
         end
         m_head = (m_head + r0 + r1) % 5;
         m_cnt = m_cnt + nal - r0 - r1;
      end
   endtask

   initial begin
      for (int e = 0; e < 5; e++) begin
         m_st[e] = 0; m_dst[e] = 0; m_slot[e] = 0;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "stall in reset", int'(stall), 0);
      chk("R1", "recover in reset", int'(recover), 0);
      chk("R1", "commit in reset", int'(commit_valid), 0);
      chk("R1", "grant in reset", int'(disp_grant), 0);
      rst_n = 1'b1;

      // fill the queue
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      chk("R2", "one buffer left, lane 0 only", int'(disp_grant), 1);
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      chk("R3", "full queue grants nothing", int'(disp_grant), 0);
      chk("R3", "full queue stalls", int'(stall), 1);
      // younger entry finishes first
      cyc(2'b00, 2'b01, 1, 0, 2'b00);
      cyc(2'b00, 2'b11, 7, 1, 2'b00);
      chk("R6", "younger finished waits for head", int'(commit_valid), 0);
      cyc(2'b00, 2'b00, 0, 0, 2'b00);
      chk("R8", "stray and repeated finish ignored", int'(commit_valid), 0);
      chk("R8", "queue still full", int'(stall), 1);
      // head finishes while dispatch presses on a full queue
      cyc(2'b11, 2'b01, 0, 0, 2'b00);
      chk("R4", "no commit in finish cycle", int'(commit_valid), 0);
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      chk("R4", "both commit after finish edge", int'(commit_valid), 3);
      chk("R9", "full at cycle start, no grant while retiring", int'(disp_grant), 0);
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      chk("R9", "space freed by retire is granted", int'(disp_grant), 3);
      chk("R2", "tags wrap around", int'(disp_tag), 8);
      // faulting entry behind a finished head
      cyc(2'b00, 2'b11, 3, 2, 2'b01);
      cyc(2'b00, 2'b00, 0, 0, 2'b00);
      chk("R5", "faulted second entry held", int'(commit_valid), 1);
      cyc(2'b11, 2'b00, 0, 0, 2'b00);
      chk("R7", "recover raised", int'(recover), 1);
      chk("R7", "no commit during recover", int'(commit_valid), 0);
      cyc(2'b01, 2'b00, 0, 0, 2'b00);
      chk("R7", "tag restarts at faulting index", int'(disp_tag[2:0]), 3);
      chk("R7", "flushed queue accepts", int'(disp_grant), 1);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] dv, fv, fe;
         int t [2];
         dv = 2'($urandom % 4);
         for (int l = 0; l < 2; l++) begin
            if (($urandom % 4) != 0 && m_cnt > 0)
               t[l] = (m_head + int'($urandom % m_cnt)) % 5;
            else
               t[l] = int'($urandom % 8);
            fv[l] = 1'($urandom % 2);
            fe[l] = (($urandom % 12) == 0);
         end
         cyc(dv, fv, t[0], t[1], fe);
      end

      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule